// File: doc/BRIEF.md
# Powered-Device Power-Up Sequencer

This block steps the power path of a device that draws its supply over a twisted-pair cable. Analog comparators outside it report, as single-bit flags, whether the line voltage is above the turn-on level or below the turn-off level, whether the pass switch has finished charging the converter input, whether a local wall adapter is present, and whether the die is too hot. From these flags the sequencer drives the pass-switch enable, the choice between the low inrush current limit and the higher operating limit, the enable of the classification current sink, and the enable of the downstream DC-DC converter.

A power-up goes through three stages. The switch closes with the inrush limit. Once charging is reported, the limit moves to the operating value and a long timer runs. When the timer ends, the converter starts. A dip below the turn-off level is only acted on if it lasts longer than a deglitch window. Two overrides sit above this sequence. A wall adapter opens the switch and lets the converter run from the adapter. A thermal fault shuts everything down, and when the fault clears the sequence restarts from the beginning. A 3-bit status output reports the current state.

Top module: `pd_power_seq`

## Requirements
- R1: From the idle state, the first clock edge that samples above_on_i high moves the block to the inrush state. In that state iso_en_o=1, ilim_oper_o=0 and conv_en_o=0.
- R2: In the inrush state, the edge that samples inrush_done_i high moves the block to the delay state. ilim_oper_o becomes 1 and conv_en_o stays 0.
- R3: conv_en_o rises exactly DELAY_CYC clock cycles after ilim_oper_o rises, and the block is then in the run state.
- R4: While the switch is on, a run of at most DG_CYC consecutive high samples of below_off_i changes no output.
- R5: When below_off_i is sampled high on DG_CYC+1 consecutive edges, the next cycle has iso_en_o, ilim_oper_o and conv_en_o at 0 and the state at idle.
- R6: An edge that samples adapter_i high puts the block in the adapter state, with iso_en_o=0 and class_en_o=0. When adapter_i is sampled low, the block returns to idle.
- R7: In the adapter state, conv_en_o is 1 exactly when supply_ok_i was high at the previous edge. The delay timer is not used in this state.
- R8: class_en_o is 1 one cycle after an edge that samples class_mode_i high, but only if that edge leaves the block idle with no adapter and no fault. Otherwise it is 0, and it falls one cycle after class_mode_i falls.
- R9: An edge that samples over_temp_i high puts the block in the fault state with all four enables at 0. The block stays there while over_temp_i is high, whatever the other inputs do.
- R10: The first edge that samples over_temp_i low moves the block to idle with its timers cleared. A later power-up starts again in the inrush state with ilim_oper_o=0.
- R11: When several events land on the same edge, the priority is: thermal fault, then adapter, then the turn-off trip, then normal sequence progress.
- R12: After reset all enables are 0 and state_o is idle. The status codes are idle=0, inrush=1, delay=2, run=3, adapter=4, fault=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| above_on_i | input | 1 | Line voltage above the turn-on threshold |
| below_off_i | input | 1 | Line voltage below the turn-off threshold |
| inrush_done_i | input | 1 | Converter input has charged to near the line voltage |
| class_mode_i | input | 1 | Line voltage is in the classification window |
| adapter_i | input | 1 | Wall adapter detected |
| supply_ok_i | input | 1 | Converter supply within its operating range |
| over_temp_i | input | 1 | Die over-temperature |
| iso_en_o | output | 1 | Pass-switch enable |
| ilim_oper_o | output | 1 | Current-limit select: 0 for inrush, 1 for operating |
| class_en_o | output | 1 | Classification current sink enable |
| conv_en_o | output | 1 | Downstream converter enable |
| state_o | output | 3 | Current sequencer state code |

## Verification
The interesting collisions happen when an override arrives on the very edge where the normal sequence would advance. The bench raises adapter_i on the edge where the delay timer expires. It expects the adapter state, with the switch open and the converter enable following supply_ok_i, and not the run state. It also raises over_temp_i and adapter_i on the same edge, and expects the fault state to win. The deglitch window is checked at both ends: a run of exactly DG_CYC high samples must leave every output alone, and one more sample must shut the path down.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_INRUSH  = 3'd1,
        ST_DELAY   = 3'd2,
        ST_RUN     = 3'd3,
        ST_ADAPTER = 3'd4,
        ST_FAULT   = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       iso;
        logic       oper;
        logic       conv;
        logic       cls;
    } seq_regs_t;

endpackage

// File: rtl/pd_seq_deglitch.sv
// Counts consecutive high samples of a level; trips on the sample after LIMIT.
module pd_seq_deglitch #(
    parameter int LIMIT = 18000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic level,
    output logic trip
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !level) begin
            cnt_d = '0;
        end else if (cnt_q != W'(LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign trip = level && !clr && (cnt_q == W'(LIMIT));

endmodule

// File: rtl/pd_seq_delay.sv
// Cycle timer: done is high in the LIMIT-th consecutive enabled cycle.
module pd_seq_delay #(
    parameter int LIMIT = 20000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = en ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = en && (cnt_q == W'(LIMIT - 1));

endmodule

// File: rtl/pd_power_seq.sv
module pd_power_seq
    import pd_seq_pkg::*;
#(
    parameter int DELAY_CYC = 20000000,
    parameter int DG_CYC    = 18000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       above_on_i,
    input  logic       below_off_i,
    input  logic       inrush_done_i,
    input  logic       class_mode_i,
    input  logic       adapter_i,
    input  logic       supply_ok_i,
    input  logic       over_temp_i,
    output logic       iso_en_o,
    output logic       ilim_oper_o,
    output logic       class_en_o,
    output logic       conv_en_o,
    output logic [2:0] state_o
);
    seq_regs_t r_d, r_q;
    logic      powered_q;
    logic      dg_trip;
    logic      dly_done;

    assign powered_q = (r_q.state == ST_INRUSH) || (r_q.state == ST_DELAY) ||
                       (r_q.state == ST_RUN);

    pd_seq_deglitch #(.LIMIT(DG_CYC)) u_dg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!powered_q),
        .level (below_off_i),
        .trip  (dg_trip)
    );

    pd_seq_delay #(.LIMIT(DELAY_CYC)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.state == ST_DELAY),
        .done  (dly_done)
    );

    always_comb begin
        seq_state_e st;
        st = r_q.state;
        if (over_temp_i) begin
            st = ST_FAULT;
        end else begin
            unique case (r_q.state)
                ST_FAULT:   st = ST_OFF;
                ST_OFF:     st = adapter_i ? ST_ADAPTER :
                                 (above_on_i ? ST_INRUSH : ST_OFF);
                ST_ADAPTER: st = adapter_i ? ST_ADAPTER : ST_OFF;
                ST_INRUSH, ST_DELAY, ST_RUN: begin
                    if (adapter_i)      st = ST_ADAPTER;
                    else if (dg_trip)   st = ST_OFF;
                    else if (r_q.state == ST_INRUSH && inrush_done_i) st = ST_DELAY;
                    else if (r_q.state == ST_DELAY && dly_done)       st = ST_RUN;
                    else                st = r_q.state;
                end
                default:    st = ST_OFF;
            endcase
        end
        r_d.state = st;
        r_d.iso   = (st == ST_INRUSH) || (st == ST_DELAY) || (st == ST_RUN);
        r_d.oper  = (st == ST_DELAY) || (st == ST_RUN);
        r_d.conv  = (st == ST_RUN) || ((st == ST_ADAPTER) && supply_ok_i);
        r_d.cls   = (st == ST_OFF) && class_mode_i && !adapter_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_OFF;
            r_q.iso   <= 1'b0;
            r_q.oper  <= 1'b0;
            r_q.conv  <= 1'b0;
            r_q.cls   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign iso_en_o    = r_q.iso;
    assign ilim_oper_o = r_q.oper;
    assign conv_en_o   = r_q.conv;
    assign class_en_o  = r_q.cls;
    assign state_o     = r_q.state;

endmodule

// File: rtl/pd_power_seq_chk.sv
module pd_power_seq_chk #(
    parameter int DELAY_CYC = 20000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       below_off_i,
    input logic       class_mode_i,
    input logic       adapter_i,
    input logic       over_temp_i,
    input logic       iso_en_o,
    input logic       ilim_oper_o,
    input logic       class_en_o,
    input logic       conv_en_o
);
    int unsigned oper_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           oper_cnt <= 0;
        else if (!ilim_oper_o)                oper_cnt <= 0;
        else if (!conv_en_o)                  oper_cnt <= oper_cnt + 1;
    end

    a_r3_conv_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conv_en_o) && iso_en_o) |-> (oper_cnt == DELAY_CYC));

    a_r2_conv_needs_oper: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_en_o && iso_en_o) |-> ilim_oper_o);

    a_r4_no_drop_without_dip: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_en_o && !below_off_i && !over_temp_i && !adapter_i) |=> iso_en_o);

    a_r6_adapter_opens_switch: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_i |=> (!iso_en_o && !class_en_o));

    a_r9_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp_i |=> (!iso_en_o && !conv_en_o && !class_en_o && !ilim_oper_o));

    a_r8_class_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        class_en_o |-> (!iso_en_o && $past(class_mode_i)));

endmodule

bind pd_power_seq pd_power_seq_chk #(.DELAY_CYC(DELAY_CYC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .below_off_i  (below_off_i),
    .class_mode_i (class_mode_i),
    .adapter_i    (adapter_i),
    .over_temp_i  (over_temp_i),
    .iso_en_o     (iso_en_o),
    .ilim_oper_o  (ilim_oper_o),
    .class_en_o   (class_en_o),
    .conv_en_o    (conv_en_o)
);

// File: tb/pd_power_seq_tb_top.sv
module pd_power_seq_tb_top;
    localparam int DLY = 40;
    localparam int DG  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_on = 0, below_off = 0, inrush_done = 0, class_mode = 0;
    logic adapter = 0, supply_ok = 0, over_temp = 0;
    logic iso_en, ilim_oper, class_en, conv_en;
    logic [2:0] state;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pd_power_seq #(.DELAY_CYC(DLY), .DG_CYC(DG)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .above_on_i(above_on), .below_off_i(below_off),
        .inrush_done_i(inrush_done), .class_mode_i(class_mode),
        .adapter_i(adapter), .supply_ok_i(supply_ok), .over_temp_i(over_temp),
        .iso_en_o(iso_en), .ilim_oper_o(ilim_oper), .class_en_o(class_en),
        .conv_en_o(conv_en), .state_o(state)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected outputs packed as {iso, oper, conv, cls, state}
    task automatic chk_all(input string req, input int exp);
        chk(req, {iso_en, ilim_oper, conv_en, class_en, state}, exp);
    endtask

    task automatic go_idle();
        above_on = 0; below_off = 0; inrush_done = 0; class_mode = 0;
        adapter = 0; supply_ok = 0; over_temp = 0;
        tick(3);
    endtask

    task automatic reach_run();
        above_on = 1; tick(1);
        inrush_done = 1; tick(1);
        tick(DLY);
    endtask

    task automatic t_reset();
        chk_all("R12 reset", {4'b0000, 3'd0});
    endtask

    task automatic t_powerup();
        above_on = 1; tick(1);
        chk_all("R1 inrush entry", {4'b1000, 3'd1});
        tick(3);
        chk_all("R1 inrush holds", {4'b1000, 3'd1});
        inrush_done = 1; tick(1);
        chk_all("R2 operating limit", {4'b1100, 3'd2});
        tick(DLY - 1);
        chk("R3 conv not yet", conv_en, 0);
        tick(1);
        chk_all("R3 run after delay", {4'b1110, 3'd3});
        go_idle();
    endtask

    task automatic t_deglitch();
        reach_run();
        below_off = 1; tick(DG);
        below_off = 0; tick(1);
        chk_all("R4 short dip ignored", {4'b1110, 3'd3});
        below_off = 1; tick(DG);
        chk_all("R5 still on at window", {4'b1110, 3'd3});
        tick(1);
        chk_all("R5 turn-off trip", {4'b0000, 3'd0});
        go_idle();
    endtask

    task automatic t_adapter();
        reach_run();
        adapter = 1; class_mode = 1; tick(1);
        chk_all("R6 adapter opens switch", {4'b0000, 3'd4});
        supply_ok = 1; tick(1);
        chk_all("R7 conv from adapter", {4'b0010, 3'd4});
        supply_ok = 0; tick(1);
        chk("R7 conv follows supply", conv_en, 0);
        adapter = 0; tick(1);
        chk("R6 adapter exit", state, 0);
        go_idle();
    endtask

    task automatic t_class();
        class_mode = 1; tick(1);
        chk_all("R8 class on", {4'b0001, 3'd0});
        class_mode = 0; tick(1);
        chk("R8 class off", class_en, 0);
        reach_run();
        class_mode = 1; tick(2);
        chk("R8 class blocked when powered", class_en, 0);
        go_idle();
    endtask

    task automatic t_fault();
        reach_run();
        over_temp = 1; tick(1);
        chk_all("R9 fault shutdown", {4'b0000, 3'd5});
        adapter = 1; supply_ok = 1; class_mode = 1; tick(3);
        chk_all("R9 fault holds", {4'b0000, 3'd5});
        adapter = 0; supply_ok = 0; class_mode = 0;
        over_temp = 0; tick(1);
        chk_all("R10 fault clears to idle", {4'b0000, 3'd0});
        tick(1);
        chk_all("R10 restart with inrush", {4'b1000, 3'd1});
        go_idle();
    endtask

    task automatic t_priority();
        reach_run();
        over_temp = 1; adapter = 1; tick(1);
        chk("R11 fault beats adapter", state, 5);
        go_idle();
        above_on = 1; tick(1);
        inrush_done = 1; tick(1);
        tick(DLY - 1);
        adapter = 1; supply_ok = 1; tick(1);
        chk_all("R11 adapter beats delay expiry", {4'b0010, 3'd4});
        go_idle();
        reach_run();
        below_off = 1; tick(DG);
        adapter = 1; tick(1);
        chk("R11 adapter beats trip", state, 4);
        go_idle();
    endtask

    initial begin
        tick(2);
        t_reset();
        rst_n = 1;
        tick(1);
        t_reset();
        t_powerup();
        t_deglitch();
        t_adapter();
        t_class();
        t_fault();
        t_priority();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule